// File: doc/BRIEF.md
# Serial Port Event Interrupt and DMA Request Unit

This unit collects the event conditions of a single serial port and turns them into one active-low interrupt request for a system interrupt controller. The conditions are receiver ready, transmitter ready, receive FIFO full and a change of the clear-to-send input. Receiver ready, transmitter ready and FIFO full are level inputs that the status register follows. A change of clear-to-send, in either direction, is caught by a two-stage synchronizer and an edge detector. It sets a sticky status bit that stays set until software clears it with a strobe.

A mask register selects which status bits may pull the request low. The FIFO-full condition never reaches the core interrupt. Its mask bit instead enables a DMA request, so that the FIFO can be emptied to memory without the core. Each port instance is tied to a fixed DMA channel, and the channel number is a parameter.

When the interrupt controller acknowledges, the unit answers in one of two ways. It can place its programmed vector on the vector bus with a valid flag, or, in autovector mode, it can raise an autovector flag and drive no vector.

Top module: `serial_event_irq`

## Requirements
- R1: After reset, irq_n is 1, dma_req is 0, vec_valid is 0, autovec is 0, the mask is all zeros and the vector register holds 0x0F.
- R2: irq_n is 0 exactly when at least one status bit among receiver ready (bit 0), transmitter ready (bit 2) and CTS change (bit 3) is set and its mask bit is 1. A change on a level input appears on irq_n two clock edges after the input changes.
- R3: A write through mask_we loads mask_bits (bit 0 receiver ready, bit 1 FIFO full, bit 2 transmitter ready, bit 3 CTS change) at the next edge, and irq_n reflects the new mask one edge later.
- R4: A rising or a falling change on cts_in sets the sticky status bit 3. With mask bit 3 set, irq_n goes low four edges after the input change and stays low while the bit is set.
- R5: A pulse on cos_clr clears status bit 3 at the next edge, and irq_n returns to 1 one edge later if no other unmasked bit is set. A pulse on cos_clr has no effect on receiver ready.
- R6: FIFO full never drives irq_n. When mask bit 1 is 1, dma_req rises two edges after fifo_full rises, stays high while fifo_full stays high, and falls two edges after fifo_full falls. When mask bit 1 is 0, dma_req stays 0.
- R7: When av_mode is 0, a one-cycle iack sampled at an edge makes vec_valid 1 with vec_out equal to the vector register, and autovec 0, for exactly the following cycle.
- R8: When av_mode is 1, an acknowledge makes autovec 1 for one cycle, while vec_valid stays 0 and vec_out stays 0.
- R9: A write through vec_we loads vec_wdata into the vector register, and the next acknowledge delivers the new value.
- R10: dma_chan constantly drives the DMA_CHAN parameter, whose default is 2 plus PORT_IDX.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_rdy | input | 1 | Receiver has data (level) |
| fifo_full | input | 1 | Receive FIFO full (level) |
| tx_rdy | input | 1 | Transmitter can accept data (level) |
| cts_in | input | 1 | Clear-to-send pin, asynchronous |
| cos_clr | input | 1 | Strobe that clears the CTS change status bit |
| mask_we | input | 1 | Mask register write enable |
| mask_bits | input | 4 | Mask value to write |
| vec_we | input | 1 | Vector register write enable |
| vec_wdata | input | VEC_W | Vector value to write |
| av_mode | input | 1 | 1 selects autovector acknowledge |
| iack | input | 1 | Interrupt acknowledge strobe |
| irq_n | output | 1 | Interrupt request, active low |
| vec_out | output | VEC_W | Vector bus |
| vec_valid | output | 1 | vec_out carries a vector |
| autovec | output | 1 | Autovector indication |
| dma_req | output | 1 | DMA request for FIFO drain |
| dma_chan | output | CH_W | Fixed DMA channel number of this port |

## Verification
The bench builds the unit with PORT_IDX set to 1, which gives channel 3 instead of the default 2 and shows that the derived channel default follows the port index. It keeps SYNC_STAGES at 2, VEC_W at 8 and the reset vector at 0x0F. With these values the four-edge CTS latency and the reset vector can be predicted and checked on the acknowledge bus. The bench toggles cts_in in both directions and clears the sticky bit between the toggles. It also fills and drains the FIFO with the DMA path enabled and then disabled.

// File: rtl/sevt_pkg.sv
package sevt_pkg;
    localparam int NSRC    = 4;
    localparam int B_RXRDY = 0;
    localparam int B_FULL  = 1;
    localparam int B_TXRDY = 2;
    localparam int B_CTS   = 3;
    // status bits allowed to reach the core interrupt (FIFO full goes to DMA)
    localparam logic [NSRC-1:0] IRQ_SRC = 4'b1101;
endpackage

// File: rtl/cts_cos_detect.sv
module cts_cos_detect #(
    parameter int   STAGES  = 2,
    parameter logic RST_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_async,
    output logic cos_pulse
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } cts_st_t;

    cts_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], cts_async};
        st_d.prev = st_q.sync[STAGES-1];
        cos_pulse = st_q.sync[STAGES-1] ^ st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sync <= {STAGES{RST_LVL}};
            st_q.prev <= RST_LVL;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/evt_status.sv
module evt_status
    import sevt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_rdy,
    input  logic            fifo_full,
    input  logic            tx_rdy,
    input  logic            cos_pulse,
    input  logic            cos_clr,
    input  logic            mask_we,
    input  logic [NSRC-1:0] mask_bits,
    output logic            irq_n,
    output logic            full_stat,
    output logic            full_en
);
    typedef struct packed {
        logic [NSRC-1:0] stat;
        logic [NSRC-1:0] mask;
        logic            irq_n;
    } stat_st_t;

    stat_st_t st_d, st_q;

    always_comb begin
        st_d              = st_q;
        st_d.stat[B_RXRDY] = rx_rdy;
        st_d.stat[B_FULL]  = fifo_full;
        st_d.stat[B_TXRDY] = tx_rdy;
        st_d.stat[B_CTS]   = cos_pulse | (st_q.stat[B_CTS] & ~cos_clr);
        if (mask_we) st_d.mask = mask_bits;
        st_d.irq_n = ~|(st_q.stat & st_q.mask & IRQ_SRC);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.stat  <= '0;
            st_q.mask  <= '0;
            st_q.irq_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_n     = st_q.irq_n;
    assign full_stat = st_q.stat[B_FULL];
    assign full_en   = st_q.mask[B_FULL];

    // R3: mask write lands at the next edge
    a_r3_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> st_q.mask == $past(mask_bits));
    // R2: a cleared mask keeps the request negated
    a_r2_mask_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mask == '0) |=> irq_n);
    // R4: a CTS change always sets the sticky bit
    a_r4_cos_sets: assert property (@(posedge clk) disable iff (!rst_n)
        cos_pulse |=> st_q.stat[B_CTS]);
    // R5: the clear strobe removes the sticky bit when no new change arrives
    a_r5_cos_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cos_clr && !cos_pulse) |=> !st_q.stat[B_CTS]);
endmodule

// File: rtl/dma_req_gen.sv
module dma_req_gen #(
    parameter int CH_W = 4,
    parameter int CHAN = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            full_stat,
    input  logic            full_en,
    output logic            dma_req,
    output logic [CH_W-1:0] dma_chan
);
    typedef struct packed {
        logic req;
    } dma_st_t;

    dma_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = full_stat & full_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.req <= 1'b0;
        else        st_q     <= st_d;
    end

    assign dma_req  = st_q.req;
    assign dma_chan = CH_W'(CHAN);

    // R6: request holds for the whole fill event
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && full_stat && full_en) |=> dma_req);
    // R6: request withdrawn once the FIFO is no longer full
    a_r6_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !full_stat |=> !dma_req);
endmodule

// File: rtl/ack_vector.sv
module ack_vector #(
    parameter int               VEC_W   = 8,
    parameter logic [VEC_W-1:0] VEC_RST = 8'h0F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vec_we,
    input  logic [VEC_W-1:0] vec_wdata,
    input  logic             iack,
    input  logic             av_mode,
    output logic [VEC_W-1:0] vec_out,
    output logic             vec_valid,
    output logic             autovec
);
    typedef struct packed {
        logic [VEC_W-1:0] vec;
        logic [VEC_W-1:0] out;
        logic             valid;
        logic             av;
    } ack_st_t;

    ack_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.out   = '0;
        st_d.valid = 1'b0;
        st_d.av    = 1'b0;
        if (vec_we) st_d.vec = vec_wdata;
        if (iack) begin
            if (av_mode) begin
                st_d.av = 1'b1;
            end else begin
                st_d.valid = 1'b1;
                st_d.out   = st_q.vec;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.vec   <= VEC_RST;
            st_q.out   <= '0;
            st_q.valid <= 1'b0;
            st_q.av    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vec_out   = st_q.out;
    assign vec_valid = st_q.valid;
    assign autovec   = st_q.av;

    // R7: vectored acknowledge returns the stored vector
    a_r7_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (iack && !av_mode) |=> (vec_valid && !autovec && vec_out == $past(st_q.vec)));
    // R8: autovector acknowledge drives no vector
    a_r8_autovec: assert property (@(posedge clk) disable iff (!rst_n)
        (iack && av_mode) |=> (autovec && !vec_valid && vec_out == '0));
    // R8: the two acknowledge answers never overlap
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({vec_valid, autovec}));
endmodule

// File: rtl/serial_event_irq.sv
module serial_event_irq
    import sevt_pkg::*;
#(
    parameter int               PORT_IDX    = 0,
    parameter int               CH_W        = 4,
    parameter int               DMA_CHAN    = 2 + PORT_IDX,
    parameter int               VEC_W       = 8,
    parameter logic [VEC_W-1:0] VEC_RST     = 8'h0F,
    parameter int               SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_rdy,
    input  logic             fifo_full,
    input  logic             tx_rdy,
    input  logic             cts_in,
    input  logic             cos_clr,
    input  logic             mask_we,
    input  logic [NSRC-1:0]  mask_bits,
    input  logic             vec_we,
    input  logic [VEC_W-1:0] vec_wdata,
    input  logic             av_mode,
    input  logic             iack,
    output logic             irq_n,
    output logic [VEC_W-1:0] vec_out,
    output logic             vec_valid,
    output logic             autovec,
    output logic             dma_req,
    output logic [CH_W-1:0]  dma_chan
);
    logic cos_pulse;
    logic full_stat;
    logic full_en;

    cts_cos_detect #(.STAGES(SYNC_STAGES), .RST_LVL(1'b1)) u_cts (
        .clk       (clk),
        .rst_n     (rst_n),
        .cts_async (cts_in),
        .cos_pulse (cos_pulse)
    );

    evt_status u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_rdy    (rx_rdy),
        .fifo_full (fifo_full),
        .tx_rdy    (tx_rdy),
        .cos_pulse (cos_pulse),
        .cos_clr   (cos_clr),
        .mask_we   (mask_we),
        .mask_bits (mask_bits),
        .irq_n     (irq_n),
        .full_stat (full_stat),
        .full_en   (full_en)
    );

    dma_req_gen #(.CH_W(CH_W), .CHAN(DMA_CHAN)) u_dma (
        .clk       (clk),
        .rst_n     (rst_n),
        .full_stat (full_stat),
        .full_en   (full_en),
        .dma_req   (dma_req),
        .dma_chan  (dma_chan)
    );

    ack_vector #(.VEC_W(VEC_W), .VEC_RST(VEC_RST)) u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .vec_we    (vec_we),
        .vec_wdata (vec_wdata),
        .iack      (iack),
        .av_mode   (av_mode),
        .vec_out   (vec_out),
        .vec_valid (vec_valid),
        .autovec   (autovec)
    );
endmodule

// File: tb/sim_serial_event_irq.sv
module sim_serial_event_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_rdy = 1'b0, fifo_full = 1'b0, tx_rdy = 1'b0, cts_in = 1'b1;
    logic       cos_clr = 1'b0, mask_we = 1'b0, vec_we = 1'b0, av_mode = 1'b0, iack = 1'b0;
    logic [3:0] mask_bits = '0;
    logic [7:0] vec_wdata = '0;
    logic       irq_n, vec_valid, autovec, dma_req;
    logic [7:0] vec_out;
    logic [3:0] dma_chan;

    serial_event_irq #(.PORT_IDX(1)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_rdy(rx_rdy), .fifo_full(fifo_full),
        .tx_rdy(tx_rdy), .cts_in(cts_in), .cos_clr(cos_clr), .mask_we(mask_we),
        .mask_bits(mask_bits), .vec_we(vec_we), .vec_wdata(vec_wdata),
        .av_mode(av_mode), .iack(iack), .irq_n(irq_n), .vec_out(vec_out),
        .vec_valid(vec_valid), .autovec(autovec), .dma_req(dma_req),
        .dma_chan(dma_chan)
    );

    always #10 clk = ~clk;  // 50 MHz

    localparam int F_IRQ = 0, F_DMA = 1, F_VV = 2, F_VEC = 3, F_AV = 4;

    typedef struct {
        int         due;
        int         fld;
        logic [7:0] val;
        string      req;
    } exp_t;

    exp_t sb[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] observe(int fld);
        case (fld)
            F_IRQ:   return {7'b0, irq_n};
            F_DMA:   return {7'b0, dma_req};
            F_VV:    return {7'b0, vec_valid};
            F_VEC:   return vec_out;
            default: return {7'b0, autovec};
        endcase
    endfunction

    task automatic check(string req, int fld, logic [7:0] got, logic [7:0] want);
        n_chk++;
        if (got !== want) begin
            n_fail++;
            $display("FAIL %s field %0d cycle %0d: got %h expected %h", req, fld, cyc, got, want);
        end
    endtask

    task automatic expect_at(int dly, int fld, logic [7:0] v, string req);
        exp_t e;
        e.due = cyc + dly; e.fld = fld; e.val = v; e.req = req;
        sb.push_back(e);
    endtask

    // monitor: compare queued expectations when their cycle comes
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            check(e.req, e.fld, observe(e.fld), e.val);
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_mask(logic [3:0] m);
        @(negedge clk); mask_we = 1'b1; mask_bits = m;
        @(negedge clk); mask_we = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk); cos_clr = 1'b1; expect_at(2, F_IRQ, 8'd1, "R5");
        @(negedge clk); cos_clr = 1'b0;
    endtask

    task automatic ack(logic mode, logic [7:0] vec_exp);
        @(negedge clk); av_mode = mode; iack = 1'b1;
        if (!mode) begin
            expect_at(1, F_VV, 8'd1, "R7");
            expect_at(1, F_VEC, vec_exp, "R7");
            expect_at(1, F_AV, 8'd0, "R7");
            expect_at(2, F_VV, 8'd0, "R7");
        end else begin
            expect_at(1, F_AV, 8'd1, "R8");
            expect_at(1, F_VV, 8'd0, "R8");
            expect_at(1, F_VEC, 8'd0, "R8");
            expect_at(2, F_AV, 8'd0, "R8");
        end
        @(negedge clk); iack = 1'b0;
        idle(2);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        expect_at(1, F_IRQ, 8'd1, "R1");
        expect_at(1, F_DMA, 8'd0, "R1");
        expect_at(1, F_VV, 8'd0, "R1");
        expect_at(1, F_AV, 8'd0, "R1");
        check("R10", 5, {4'b0, dma_chan}, 8'd3);
        idle(2);

        // R1/R2: zero mask after reset keeps receiver ready silent
        @(negedge clk); rx_rdy = 1'b1; expect_at(2, F_IRQ, 8'd1, "R1");
        idle(3);
        // R3: enabling bit 0 raises the request
        @(negedge clk); mask_we = 1'b1; mask_bits = 4'b0001; expect_at(2, F_IRQ, 8'd0, "R3");
        @(negedge clk); mask_we = 1'b0;
        idle(3);
        // R5: clear strobe leaves receiver ready alone
        @(negedge clk); cos_clr = 1'b1; expect_at(2, F_IRQ, 8'd0, "R5"); expect_at(4, F_IRQ, 8'd0, "R5");
        @(negedge clk); cos_clr = 1'b0;
        idle(4);
        // R2: source removal negates
        @(negedge clk); rx_rdy = 1'b0; expect_at(2, F_IRQ, 8'd1, "R2");
        idle(3);
        // R2/R3: transmitter ready together with a new mask
        @(negedge clk); tx_rdy = 1'b1; mask_we = 1'b1; mask_bits = 4'b0100; expect_at(2, F_IRQ, 8'd0, "R2");
        @(negedge clk); mask_we = 1'b0;
        idle(3);
        @(negedge clk); tx_rdy = 1'b0; expect_at(2, F_IRQ, 8'd1, "R2");
        idle(3);

        // R4: CTS falling change
        write_mask(4'b1000);
        idle(2);
        @(negedge clk); cts_in = 1'b0; expect_at(3, F_IRQ, 8'd1, "R4"); expect_at(4, F_IRQ, 8'd0, "R4");
        idle(6);
        @(negedge clk); expect_at(1, F_IRQ, 8'd0, "R4");  // sticky
        idle(2);
        pulse_clear();
        idle(4);
        // R4: CTS rising change
        @(negedge clk); cts_in = 1'b1; expect_at(4, F_IRQ, 8'd0, "R4");
        idle(6);
        pulse_clear();
        idle(4);

        // R6: FIFO full with DMA enabled
        write_mask(4'b0010);
        idle(2);
        @(negedge clk); fifo_full = 1'b1; expect_at(2, F_DMA, 8'd1, "R6"); expect_at(2, F_IRQ, 8'd1, "R6");
        idle(5);
        @(negedge clk); expect_at(1, F_DMA, 8'd1, "R6");
        idle(1);
        @(negedge clk); fifo_full = 1'b0; expect_at(1, F_DMA, 8'd1, "R6"); expect_at(2, F_DMA, 8'd0, "R6");
        idle(4);
        // R6: FIFO full with DMA disabled
        write_mask(4'b0000);
        idle(2);
        @(negedge clk); fifo_full = 1'b1; expect_at(2, F_DMA, 8'd0, "R6"); expect_at(3, F_DMA, 8'd0, "R6");
        idle(4);
        @(negedge clk); fifo_full = 1'b0;
        idle(3);

        // R1/R7: vectored acknowledge with the reset vector
        ack(1'b0, 8'h0F);
        // R9: new vector is delivered
        @(negedge clk); vec_we = 1'b1; vec_wdata = 8'hA5;
        @(negedge clk); vec_we = 1'b0;
        idle(1);
        ack(1'b0, 8'hA5);
        // R8: autovector acknowledge
        ack(1'b1, 8'h00);
        idle(4);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (R1 to R10 sequence) got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule